// File: doc/BRIEF.md
# Prefix-Code Field Encoder

This block turns one syntax value into a short ordered run of (bits, length) fields that a downstream bit packer appends to a stream. Four coding schemes are selectable per request:

- plain unsigned Exp-Golomb;
- signed Exp-Golomb, which folds a two's-complement value onto the unsigned range before coding;
- a variable-length code that places an explicit 1 marker between a zero run and a suffix;
- a bounded non-symmetric code for values below a known maximum.

Every field carries at most 32 meaningful bits, right-aligned. All bits above the field length are zero.

Requests enter on a valid/ready port and fields leave on a second valid/ready port. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. The block then owns the request and presents its fields one per output handshake, in order, with `out_last` marking the final field. A field stays unchanged while `out_valid` is high and `out_ready` is low.

`in_ready` is high when no fields are pending. It is also high in the cycle the last pending field is taken, so back-to-back requests flow without a gap. Inputs that cannot be coded produce a single zero-length field with `out_err` set, in place of any code.

Top module: `prefix_code_enc`

## Requirements
- R1: After reset `out_valid` is 0 and `in_ready` is 1.
- R2: Mode 0 (unsigned): let c = value+1 and x = bit length of c. When x > 1 the block emits a field (0, x−1) and then a field (c, x). When value is 0 it emits the single field (1, 1).
- R3: Mode 1 (signed, value read as 32-bit two's complement): 0 maps to 0, a positive v maps to 2v−1, and a negative v maps to 2|v|. The mapped result is then coded exactly as in R2.
- R4: In modes 0 and 1, if the code value (mapped value + 1) reaches 2^32, the block emits one field with length 0, bits 0, `out_err`=1 and `out_last`=1.
- R5: Mode 2 (marker): let p = value+1 computed on 33 bits, and z = (bit length of p) − 1.
  - When z > 0 the block emits three fields in this order: (0, z), then (1, 1), then (low z bits of p, z).
  - When z = 0 it emits only (1, 1).
  - The largest value gives z = 32.
- R6: Mode 3 (bounded, maximum on `in_bound`): let w = bit length of the maximum and m = 2^w − maximum. A value below m is emitted as the single field (value, w−1).
- R7: Mode 3, value at or above m: with d = value − m, the block emits the single field (((d>>1)+m)<<1 | (d&1), w). The value is assumed below the maximum.
- R8: Mode 3 with a maximum below 2 (w ≤ 1) produces the error field described in R4.
- R9: The first field of a request is valid in the cycle after the accepting edge. While a field is stalled it holds steady and `in_ready` stays low. Each further field follows one cycle after the previous transfer.
- R10: Every non-error field has a length from 1 to 32, and its bits above that length are zero. `out_last` is set only on the final field of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Request can be taken this cycle |
| in_mode | input | 2 | 0 unsigned, 1 signed, 2 marker, 3 bounded |
| in_value | input | DW | Value to code (two's complement in mode 1) |
| in_bound | input | DW | Maximum for mode 3, ignored otherwise |
| out_valid | output | 1 | Field present |
| out_ready | input | 1 | Downstream takes the field |
| out_bits | output | DW | Field bits, right-aligned |
| out_len | output | LW | Field length in bits (0 only for an error field) |
| out_last | output | 1 | Final field of the request |
| out_err | output | 1 | Request could not be coded |

## Verification
A request accepted on an edge shows its first field at the next negative edge. Each later field appears one cycle after the edge on which the previous one was taken. The bench drives and samples only on negative edges, and a scoreboard compares fields in order as they transfer.

One directed case stalls the output port. It checks that the first field is present exactly one cycle after acceptance, that the field holds for several cycles, and that `in_ready` stays low meanwhile. Random back-pressure then exercises the follow-on timing and the last-field overlap of `in_ready`.

// File: rtl/pce_pkg.sv
package pce_pkg;
  typedef enum logic [1:0] {
    MODE_UE   = 2'd0,
    MODE_SE   = 2'd1,
    MODE_UVLC = 2'd2,
    MODE_NS   = 2'd3
  } pce_mode_e;

  localparam int unsigned FIELDS_MAX = 3;
  localparam int unsigned IDX_W      = $clog2(FIELDS_MAX + 1);
endpackage

// File: rtl/pce_bitlen.sv
module pce_bitlen #(
  parameter int W  = 33,
  localparam int BW = $clog2(W + 1)
) (
  input  logic [W-1:0]  x,
  output logic [BW-1:0] len
);
  always_comb begin
    len = '0;
    for (int i = 0; i < W; i++) begin
      if (x[i]) len = BW'(i + 1);
    end
  end
endmodule

// File: rtl/pce_signmap.sv
module pce_signmap #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] value,
  output logic [DW+1:0] mapped
);
  logic [DW:0]   ext, mag;
  logic [DW+1:0] dbl;

  always_comb begin
    ext = {value[DW-1], value};
    mag = value[DW-1] ? (~ext + 1'b1) : ext;
    dbl = {mag, 1'b0};
    if (value == '0)        mapped = '0;
    else if (value[DW-1])   mapped = dbl;
    else                    mapped = dbl - 1'b1;
  end
endmodule

// File: rtl/pce_plan.sv
module pce_plan
  import pce_pkg::*;
#(
  parameter int DW = 32,
  localparam int LW = $clog2(DW + 1),
  localparam int FM = FIELDS_MAX
) (
  input  pce_mode_e             mode,
  input  logic [DW-1:0]         value,
  input  logic [DW-1:0]         bound,
  output logic [FM-1:0][DW-1:0] f_bits,
  output logic [FM-1:0][LW-1:0] f_len,
  output logic [IDX_W-1:0]      f_cnt,
  output logic                  f_err
);
  localparam int XW = DW + 2;
  localparam int BW = $clog2(DW + 2);

  logic [XW-1:0] mapped, ue_src, code, m, diff, ns_long, vx;
  logic [DW:0]   vp1, len_src;
  logic [BW-1:0] blen;
  logic          ue_ovf;

  function automatic logic [DW-1:0] trim(input logic [XW-1:0] x, input logic [BW-1:0] n);
    logic [XW-1:0] msk;
    msk  = (XW'(1) << n) - XW'(1);
    trim = DW'(x & msk);
  endfunction

  pce_signmap #(.DW(DW)) u_map (.value(value), .mapped(mapped));

  always_comb begin
    vx      = XW'(value);
    ue_src  = (mode == MODE_SE) ? mapped : vx;
    code    = ue_src + XW'(1);
    ue_ovf  = |code[XW-1:DW];
    vp1     = {1'b0, value} + 1'b1;
    case (mode)
      MODE_NS:   len_src = {1'b0, bound};
      MODE_UVLC: len_src = vp1;
      default:   len_src = {1'b0, code[DW-1:0]};
    endcase
  end

  pce_bitlen #(.W(DW + 1)) u_len (.x(len_src), .len(blen));

  always_comb begin
    m       = (XW'(1) << blen) - XW'(bound);
    diff    = vx - m;
    ns_long = ((((diff >> 1) + m) << 1) | XW'(diff[0]));
  end

  always_comb begin
    f_bits = '0;
    f_len  = '0;
    f_cnt  = IDX_W'(1);
    f_err  = 1'b0;
    case (mode)
      MODE_UE, MODE_SE: begin
        if (ue_ovf) begin
          f_err = 1'b1;
        end else if (blen > BW'(1)) begin
          f_len[0]  = LW'(blen - BW'(1));
          f_bits[1] = trim(code, blen);
          f_len[1]  = LW'(blen);
          f_cnt     = IDX_W'(2);
        end else begin
          f_bits[0] = DW'(1);
          f_len[0]  = LW'(1);
        end
      end
      MODE_UVLC: begin
        if (blen > BW'(1)) begin
          f_len[0]  = LW'(blen - BW'(1));
          f_bits[1] = DW'(1);
          f_len[1]  = LW'(1);
          f_bits[2] = trim(XW'(vp1), blen - BW'(1));
          f_len[2]  = LW'(blen - BW'(1));
          f_cnt     = IDX_W'(3);
        end else begin
          f_bits[0] = DW'(1);
          f_len[0]  = LW'(1);
        end
      end
      default: begin
        if (blen <= BW'(1)) begin
          f_err = 1'b1;
        end else if (vx < m) begin
          f_bits[0] = trim(vx, blen - BW'(1));
          f_len[0]  = LW'(blen - BW'(1));
        end else begin
          f_bits[0] = trim(ns_long, blen);
          f_len[0]  = LW'(blen);
        end
      end
    endcase
  end
endmodule

// File: rtl/prefix_code_enc.sv
module prefix_code_enc
  import pce_pkg::*;
#(
  parameter int DW = 32,
  localparam int LW = $clog2(DW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    in_mode,
  input  logic [DW-1:0] in_value,
  input  logic [DW-1:0] in_bound,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_bits,
  output logic [LW-1:0] out_len,
  output logic          out_last,
  output logic          out_err
);
  localparam int FM = FIELDS_MAX;

  logic [FM-1:0][DW-1:0] p_bits, q_bits;
  logic [FM-1:0][LW-1:0] p_len, q_len;
  logic [IDX_W-1:0]      p_cnt, q_cnt, q_idx;
  logic                  p_err, q_err, busy;
  logic                  accept, fire, done;

  pce_plan #(.DW(DW)) u_plan (
    .mode  (pce_mode_e'(in_mode)),
    .value (in_value),
    .bound (in_bound),
    .f_bits(p_bits),
    .f_len (p_len),
    .f_cnt (p_cnt),
    .f_err (p_err)
  );

  assign out_valid = busy;
  assign out_bits  = q_bits[q_idx];
  assign out_len   = q_len[q_idx];
  assign out_last  = (q_idx == q_cnt - IDX_W'(1));
  assign out_err   = q_err;
  assign fire      = busy & out_ready;
  assign done      = fire & out_last;
  assign in_ready  = ~busy | done;
  assign accept    = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      q_idx  <= '0;
      q_cnt  <= IDX_W'(1);
      q_err  <= 1'b0;
      q_bits <= '0;
      q_len  <= '0;
    end else if (accept) begin
      busy   <= 1'b1;
      q_idx  <= '0;
      q_cnt  <= p_cnt;
      q_err  <= p_err;
      q_bits <= p_bits;
      q_len  <= p_len;
    end else if (done) begin
      busy   <= 1'b0;
    end else if (fire) begin
      q_idx  <= q_idx + IDX_W'(1);
    end
  end

  assert_hold_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_bits) && $stable(out_len) && $stable(out_last));

  assert_drain_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && out_last && !in_valid |=> !out_valid);

  assert_len_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_err |-> out_len <= LW'(DW) && out_len != '0 && (out_bits >> out_len) == '0);

  assert_err_shape_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_last && out_len == '0 && out_bits == '0);
endmodule

// File: tb/sim_prefix_code_enc.sv
module sim_prefix_code_enc;
  typedef struct {
    logic [31:0] bits;
    int          len;
    bit          last;
    bit          err;
    string       tag;
  } fld_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [1:0]  in_mode = '0;
  logic [31:0] in_value = '0, in_bound = '0;
  logic        out_valid, out_last, out_err;
  logic        out_ready = 1'b0;
  logic [31:0] out_bits;
  logic [5:0]  out_len;

  int   n_run = 0, n_fail = 0, rdy_mode = 0, rdy_cnt = 0;
  fld_t exp_q[$];

  always #4 clk = ~clk;

  prefix_code_enc u0 (.*);

  always @(posedge clk) begin
    #2;
    rdy_cnt++;
    case (rdy_mode)
      0: out_ready = 1'b1;
      1: out_ready = rdy_cnt[0] ^ rdy_cnt[2];
      default: out_ready = 1'b0;
    endcase
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  function automatic int bitlen(input longint x);
    int n = 0;
    while (x > 0) begin x = x >> 1; n++; end
    return n;
  endfunction

  function automatic void push(input longint b, input int l, input bit last, input bit e, input string t);
    fld_t f;
    f.bits = b[31:0]; f.len = l; f.last = last; f.err = e; f.tag = t;
    exp_q.push_back(f);
  endfunction

  function automatic void model(input int mode, input logic [31:0] v, input logic [31:0] mx, input string t);
    longint src, c, p, mm, d;
    int x, z, w, sv;
    if (mode <= 1) begin
      sv  = $signed(v);
      src = longint'(v);
      if (mode == 1) src = (sv == 0) ? 0 : (sv > 0 ? 2 * longint'(sv) - 1 : -2 * longint'(sv));
      c = src + 1;
      if (c >= 64'h1_0000_0000) begin push(0, 0, 1, 1, t); return; end
      x = bitlen(c);
      if (x > 1) push(0, x - 1, 0, 0, t);
      push(c, x, 1, 0, t);
    end else if (mode == 2) begin
      p = longint'(v) + 1;
      z = bitlen(p) - 1;
      if (z == 0) push(1, 1, 1, 0, t);
      else begin
        push(0, z, 0, 0, t);
        push(1, 1, 0, 0, t);
        push(p & ((64'd1 << z) - 1), z, 1, 0, t);
      end
    end else begin
      w = bitlen(longint'(mx));
      if (w <= 1) begin push(0, 0, 1, 1, t); return; end
      mm = (64'd1 << w) - longint'(mx);
      if (longint'(v) < mm) push(longint'(v), w - 1, 1, 0, t);
      else begin
        d = longint'(v) - mm;
        push((((d >> 1) + mm) << 1) | (d & 1), w, 1, 0, t);
      end
    end
  endfunction

  task automatic send(input int mode, input logic [31:0] v, input logic [31:0] mx, input string t);
    model(mode, v, mx, t);
    @(negedge clk);
    in_valid = 1'b1; in_mode = 2'(mode); in_value = v; in_bound = mx;
    while (!in_ready) @(negedge clk);
    @(posedge clk);
    #1 in_valid = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected field", out_bits, 0);
      else begin
        fld_t e;
        e = exp_q.pop_front();
        chk(out_bits == e.bits, {e.tag, " bits"}, out_bits, e.bits);
        chk(int'(out_len) == e.len, {e.tag, " len"}, out_len, e.len);
        chk(out_last == e.last && out_err == e.err, {e.tag, " last/err R10"},
            {out_last, out_err}, {e.last, e.err});
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R9 actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid in reset", out_valid, 0);
    chk(in_ready == 1'b1, "R1 in_ready in reset", in_ready, 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(out_valid == 1'b0 && in_ready == 1'b1, "R1 after reset", {out_valid, in_ready}, 2'b01);

    // R9 directed: latency and hold under stall
    rdy_mode = 2;
    send(0, 32'd6, 0, "R9 R2 ue6");
    @(negedge clk);
    chk(out_valid == 1'b1, "R9 first field one cycle after accept", out_valid, 1);
    chk(out_len == 6'd2 && out_bits == 0, "R9 first field content", out_len, 2);
    repeat (3) @(negedge clk);
    chk(out_valid && out_len == 6'd2 && out_bits == 0, "R9 hold while stalled", out_len, 2);
    chk(in_ready == 1'b0, "R9 in_ready low while pending", in_ready, 0);
    rdy_mode = 0;

    // R2 unsigned
    send(0, 0, 0, "R2 ue0");
    send(0, 1, 0, "R2 ue1");
    send(0, 2, 0, "R2 ue2");
    send(0, 32'hFFFF_FFFE, 0, "R2 ue max");
    // R4 overflow
    send(0, 32'hFFFF_FFFF, 0, "R4 ue ovf");
    // R3 signed
    send(1, 0, 0, "R3 se0");
    send(1, 1, 0, "R3 se+1");
    send(1, 32'hFFFF_FFFF, 0, "R3 se-1");
    send(1, 2, 0, "R3 se+2");
    send(1, 32'hFFFF_FFFE, 0, "R3 se-2");
    send(1, 32'h7FFF_FFFF, 0, "R3 se max pos");
    send(1, 32'h8000_0001, 0, "R3 se big neg");
    send(1, 32'h8000_0000, 0, "R4 se ovf");
    // R5 marker code
    send(2, 0, 0, "R5 uvlc0");
    send(2, 1, 0, "R5 uvlc1");
    send(2, 5, 0, "R5 uvlc5");
    send(2, 32'h7FFF_FFFF, 0, "R5 uvlc 2^31-1");
    send(2, 32'hFFFF_FFFF, 0, "R5 uvlc z32");
    // R6 / R7 bounded
    for (int k = 0; k < 5; k++) send(3, k, 5, k < 3 ? "R6 ns max5" : "R7 ns max5");
    send(3, 3, 4, "R6 ns max4");
    send(3, 0, 2, "R6 ns max2 v0");
    send(3, 1, 2, "R6 ns max2 v1");
    send(3, 5, 32'h8000_0000, "R6 ns wide");
    send(3, 0, 32'hFFFF_FFFF, "R6 ns full");
    send(3, 32'hFFFF_FFFE, 32'hFFFF_FFFF, "R7 ns full top");
    // R8 errors
    send(3, 0, 1, "R8 ns max1");
    send(3, 0, 0, "R8 ns max0");

    // random under back-pressure
    rdy_mode = 1;
    for (int k = 0; k < 300; k++) begin
      int md;
      logic [31:0] v, mx;
      md = int'($urandom % 4);
      v  = (k % 2 == 1) ? ($urandom % 64) : $urandom;
      if (md == 1 && k % 4 == 1) v = -v;
      mx = (k % 3 == 0) ? ($urandom % 20) + 2 : ($urandom | 32'h2);
      if (md == 3) v = v % mx;
      case (md)
        0: send(md, v, mx, "R2 rand");
        1: send(md, v, mx, "R3 rand");
        2: send(md, v, mx, "R5 rand");
        default: send(md, v, mx, "R7 rand");
      endcase
    end

    rdy_mode = 0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R9 idle after drain", out_valid, 0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule